// File: doc/BRIEF.md
# Preemptive Time-Slice Task Sequencer

This block is a hardware round-robin scheduler for up to four software tasks sharing one processor. Each task slot has a 6-bit time allotment, measured in ticks. A tick is one overflow of an 8-bit timer that advances once every (prescale + 1) pulses of a tick enable input. When the running task uses up its allotment, the sequencer moves to the next live task in list order. A task can also give up the rest of its slice early through a yield request. A slot whose allotment is zero is empty and is never selected.

The processor's return stack is shared and cut into contiguous per-task regions, each described by a base value. Location 0 belongs to no task. The sequencer shows the running task's region bounds. On every task change it captures the outgoing task's live stack pointer and presents the incoming task's saved pointer, together with a one-cycle swap pulse, so the processor can reload it. A saved pointer starts at its region base minus one, which marks that task's stack as empty.

Top module: `task_slice_sequencer`

## Requirements
- R1: While reset is held, `swap_pulse` and `idle` are 0 and `cur_task` is 0. The first clock edge after reset selects the first live slot starting from index 0. `swap_pulse` is high in the next cycle, and `sp_restore` then equals that task's base minus one.
- R2: A running task is preempted after exactly N*256*(P+1) pulses of `tick_in`. N is its 6-bit allotment (1..63) and P is `cfg_prescale`. With `tick_in` held high, consecutive expiry swap pulses are N*256*(P+1) cycles apart. Cycles with `tick_in` low do not count.
- R3: Tasks are taken in ascending index order. The candidate index returns to 0 whenever it is not less than `cfg_task_count`, so slots at or above the count never run.
- R4: A one-cycle `yield_req` makes `swap_pulse` high and `cur_task` advance in the next cycle. A yield in the same cycle as allotment expiry produces a single swap and a single step of `cur_task`.
- R5: Slots with a zero allotment are skipped within the same swap decision. If the running task is the only live slot, a swap reselects it and still pulses.
- R6: When `cfg_task_count` is 0 or every counted slot is empty, `idle` is 1 and `swap_pulse` stays 0.
- R7: On a swap, the value of `sp_cur` is stored for the outgoing task. `sp_restore` then shows the incoming task's stored value, or its base minus one if that task has never been swapped out since reset. `sp_restore` changes only in cycles where `swap_pulse` is high.
- R8: `region_lo` is the running task's base. `region_hi` is the next task's base minus one, or 31 (the top stack location) for the last counted task. Bases are packed 5 bits per task, task 0 in bits [4:0].
- R9: `swap_pulse` lasts one cycle per swap, and `cur_task` changes only in a cycle where `swap_pulse` is high. Allotments are packed 6 bits per task, task 0 in bits [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_task_count | input | 3 | Number of task slots in the list (values above 4 act as 4) |
| cfg_slice | input | 24 | Per-task allotment, 6 bits each, task 0 lowest; 0 = empty slot |
| cfg_base | input | 20 | Per-task stack region base, 5 bits each, task 0 lowest |
| cfg_prescale | input | 8 | Prescaler setting P; the timer advances every P+1 tick pulses |
| tick_in | input | 1 | Time-base enable pulse |
| yield_req | input | 1 | Running task gives up the rest of its slice |
| sp_cur | input | 5 | Live return-stack pointer of the running task |
| cur_task | output | 2 | Index of the running task |
| swap_pulse | output | 1 | One-cycle marker of a task change |
| sp_restore | output | 5 | Pointer the processor loads for the incoming task |
| region_lo | output | 5 | Lowest stack location of the running task |
| region_hi | output | 5 | Highest stack location of the running task |
| idle | output | 1 | No live task is configured |

## Verification
The bench drives a yield into the exact cycle in which the allotment runs out. A design that treats the two causes separately would advance two tasks or pulse twice. It measures the period between expiry pulses at two prescale settings and at half-rate `tick_in`. An off-by-one in the slice counter or prescaler would shift the period by whole ticks or prescaler steps. It runs lists with empty slots, with a single live slot, and with a live slot beyond the count. A wrong wrap or skip rule would land on an empty or uncounted slot or fall idle. It also swaps stack pointers back and forth. A design that saves into the incoming slot, or forgets the base-minus-one start, would restore the wrong pointer.

// File: rtl/seq_pkg.sv
// Shared types for the time-slice sequencer.
// Assumes nothing beyond the standard language.
package seq_pkg;

    // Sequencer control state: BOOT picks the first task after reset,
    // RUN times the running task, IDLE waits for a live slot.
    typedef enum logic [1:0] {
        SEQ_BOOT = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_IDLE = 2'd2
    } seq_state_t;

    // Width of an index into n slots, at least one bit.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/seq_tick_gen.sv
// Tick generator: a prescaler followed by a timer of TMR_W bits.
// The timer advances once every (prescale + 1) tick_in pulses, and each
// wrap of the timer is one tick. 'clear' restarts both stages, so every
// slice begins from a whole tick. Assumes prescale is stable while running.
module seq_tick_gen #(
    parameter int PRE_W = 8,
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick_in,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;
    logic [TMR_W-1:0] tmr_q;
    logic             pre_wrap;

    // Prescaler reaches its terminal count on this enable pulse.
    assign pre_wrap = tick_in && (pre_q == prescale);

    // Prescaler and timer advance; both restart on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_q <= '0;
            tmr_q <= '0;
        end else if (tick_in) begin
            if (pre_wrap) begin
                pre_q <= '0;
                tmr_q <= tmr_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // A tick is issued when the timer is about to wrap.
    assign tick = pre_wrap && (&tmr_q);

endmodule

// File: rtl/seq_pick_next.sv
// Next-task finder (combinational). Starting either from index 0
// (from_start) or from the slot after 'cur', it walks the list in order,
// wraps to 0 whenever the index is not below 'limit', and returns the
// first slot with a non-zero allotment. Walks NTASK candidates, so the
// running slot itself is the last candidate. Assumes limit <= NTASK.
module seq_pick_next #(
    parameter int NTASK   = 4,
    parameter int SLICE_W = 6,
    parameter int IDX_W   = 2,
    parameter int CNT_W   = 3
) (
    input  logic                     from_start,
    input  logic [IDX_W-1:0]         cur,
    input  logic [CNT_W-1:0]         limit,
    input  logic [NTASK*SLICE_W-1:0] slices,
    output logic                     found,
    output logic [IDX_W-1:0]         next_idx
);

    // One step along the list with the wrap rule.
    function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] x,
                                              input logic [CNT_W-1:0] lim);
        logic [CNT_W-1:0] nx;
        nx = x + 1'b1;
        return (nx >= lim) ? '0 : nx;
    endfunction

    // Non-zero test of the allotment held by slot x.
    function automatic logic slot_live(input logic [CNT_W-1:0] x,
                                       input logic [NTASK*SLICE_W-1:0] s);
        logic live;
        live = 1'b0;
        for (int j = 0; j < NTASK; j++) begin
            if (CNT_W'(j) == x) live = (s[j*SLICE_W +: SLICE_W] != '0);
        end
        return live;
    endfunction

    // Scan the candidates in list order; the first live one wins.
    always_comb begin
        logic [CNT_W-1:0] cand;
        found    = 1'b0;
        next_idx = '0;
        cand     = from_start ? '0 : step(CNT_W'(cur), limit);
        for (int k = 0; k < NTASK; k++) begin
            if (!found && (cand < limit) && slot_live(cand, slices)) begin
                found    = 1'b1;
                next_idx = IDX_W'(cand);
            end
            cand = step(cand, limit);
        end
    end

endmodule

// File: rtl/seq_ctx_store.sv
// Per-task saved return-stack pointers. Reset loads each slot with its
// region base minus one (empty stack). One write port stores the outgoing
// task's pointer; one read port gives the incoming task's pointer.
// Assumes bases are stable during reset.
module seq_ctx_store #(
    parameter int NTASK = 4,
    parameter int SP_W  = 5,
    parameter int IDX_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NTASK*SP_W-1:0] bases,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [SP_W-1:0]       wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [SP_W-1:0]       rd_data
);

    logic [NTASK*SP_W-1:0] slots_flat;

    for (genvar i = 0; i < NTASK; i++) begin : g_slot
        logic [SP_W-1:0] sp_q;

        // Hold one task's pointer; reset to its base minus one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sp_q <= bases[i*SP_W +: SP_W] - 1'b1;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                sp_q <= wr_data;
            end
        end

        assign slots_flat[i*SP_W +: SP_W] = sp_q;
    end

    // Read mux over the slots.
    always_comb begin
        rd_data = '0;
        for (int j = 0; j < NTASK; j++) begin
            if (rd_idx == IDX_W'(j)) rd_data = slots_flat[j*SP_W +: SP_W];
        end
    end

endmodule

// File: rtl/task_slice_sequencer.sv
// Preemptive time-slice task sequencer (top).
// Runs up to NTASK tasks round robin. Each task is preempted when its
// allotment of ticks runs out or when it yields. The block exposes the
// running task's stack region and swaps per-task stack pointers.
// Assumes configuration is changed only while reset is held, and that
// bases ascend with task index.
module task_slice_sequencer
    import seq_pkg::*;
#(
    parameter int NTASK   = 4,
    parameter int SLICE_W = 6,
    parameter int SP_W    = 5,
    parameter int PRE_W   = 8,
    parameter int TMR_W   = 8,
    localparam int IDX_W  = idx_bits(NTASK),
    localparam int CNT_W  = $clog2(NTASK + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         cfg_task_count,
    input  logic [NTASK*SLICE_W-1:0] cfg_slice,
    input  logic [NTASK*SP_W-1:0]    cfg_base,
    input  logic [PRE_W-1:0]         cfg_prescale,
    input  logic                     tick_in,
    input  logic                     yield_req,
    input  logic [SP_W-1:0]          sp_cur,
    output logic [IDX_W-1:0]         cur_task,
    output logic                     swap_pulse,
    output logic [SP_W-1:0]          sp_restore,
    output logic [SP_W-1:0]          region_lo,
    output logic [SP_W-1:0]          region_hi,
    output logic                     idle
);

    localparam logic [SP_W-1:0] STACK_TOP = {SP_W{1'b1}};

    seq_state_t         state_q;
    logic [SLICE_W-1:0] left_q;
    logic [CNT_W-1:0]   limit;
    logic               boot_mode;
    logic               found;
    logic [IDX_W-1:0]   next_idx;
    logic               tick;
    logic               expire;
    logic               swap_req;
    logic               swap_now;
    logic               save_en;
    logic [SP_W-1:0]    stored_sp;
    logic [SP_W-1:0]    restore_val;
    logic [SLICE_W-1:0] next_slice;

    // Clamp the configured count to the number of slots.
    assign limit = (cfg_task_count > CNT_W'(NTASK)) ? CNT_W'(NTASK) : cfg_task_count;

    // Outside RUN the next pick starts from index 0 inclusive.
    assign boot_mode = (state_q != SEQ_RUN);

    seq_pick_next #(
        .NTASK  (NTASK),
        .SLICE_W(SLICE_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) u_pick (
        .from_start(boot_mode),
        .cur       (cur_task),
        .limit     (limit),
        .slices    (cfg_slice),
        .found     (found),
        .next_idx  (next_idx)
    );

    seq_tick_gen #(
        .PRE_W(PRE_W),
        .TMR_W(TMR_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (swap_now || boot_mode),
        .tick_in (tick_in),
        .prescale(cfg_prescale),
        .tick    (tick)
    );

    // Swap causes: expiry on the last tick of the slice, or a yield; both
    // in one cycle make a single request.
    assign expire   = (state_q == SEQ_RUN) && tick && (left_q == SLICE_W'(1));
    assign swap_req = (state_q == SEQ_RUN) && (expire || yield_req);
    assign swap_now = found && (boot_mode || swap_req);
    assign save_en  = found && swap_req;

    seq_ctx_store #(
        .NTASK(NTASK),
        .SP_W (SP_W),
        .IDX_W(IDX_W)
    ) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .bases  (cfg_base),
        .wr_en  (save_en),
        .wr_idx (cur_task),
        .wr_data(sp_cur),
        .rd_idx (next_idx),
        .rd_data(stored_sp)
    );

    // Reselecting the running task hands back its live pointer.
    assign restore_val = (save_en && (next_idx == cur_task)) ? sp_cur : stored_sp;

    // Allotment of the incoming task.
    always_comb begin
        next_slice = '0;
        for (int j = 0; j < NTASK; j++) begin
            if (next_idx == IDX_W'(j)) next_slice = cfg_slice[j*SLICE_W +: SLICE_W];
        end
    end

    // Control state, running task, slice counter and restore register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_BOOT;
            cur_task   <= '0;
            left_q     <= '0;
            swap_pulse <= 1'b0;
            sp_restore <= '0;
        end else begin
            swap_pulse <= swap_now;
            state_q    <= found ? SEQ_RUN : SEQ_IDLE;
            if (swap_now) begin
                cur_task   <= next_idx;
                left_q     <= next_slice;
                sp_restore <= restore_val;
            end else if ((state_q == SEQ_RUN) && tick && (left_q > SLICE_W'(1))) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign idle = (state_q == SEQ_IDLE);

    // Region bounds of the running task.
    always_comb begin
        region_lo = '0;
        region_hi = STACK_TOP;
        for (int j = 0; j < NTASK; j++) begin
            if (cur_task == IDX_W'(j)) begin
                region_lo = cfg_base[j*SP_W +: SP_W];
                if ((j + 1 < NTASK) && (CNT_W'(j + 1) < limit)) begin
                    region_hi = cfg_base[((j + 1) % NTASK)*SP_W +: SP_W] - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/seq_checker.sv
// Property checker for the time-slice sequencer, bound to the top.
// Assumes configuration is stable outside reset.
module seq_checker #(
    parameter int NTASK   = 4,
    parameter int SLICE_W = 6,
    parameter int SP_W    = 5,
    parameter int IDX_W   = 2,
    parameter int CNT_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CNT_W-1:0]         cfg_task_count,
    input logic [NTASK*SLICE_W-1:0] cfg_slice,
    input logic [IDX_W-1:0]         cur_task,
    input logic                     swap_pulse,
    input logic [SP_W-1:0]          sp_restore,
    input logic [SP_W-1:0]          region_lo,
    input logic [SP_W-1:0]          region_hi,
    input logic                     idle
);

    // Allotment of the running task, taken from the configuration.
    logic [SLICE_W-1:0] cur_slice;
    always_comb begin
        cur_slice = '0;
        for (int j = 0; j < NTASK; j++) begin
            if (cur_task == IDX_W'(j)) cur_slice = cfg_slice[j*SLICE_W +: SLICE_W];
        end
    end

    // R6: no swaps while idle.
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !swap_pulse);

    // R3: a newly selected task lies below the configured count.
    p_in_list_r3: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> ({1'b0, cur_task} < {1'b0, cfg_task_count}));

    // R5: a newly selected task never has an empty allotment.
    p_not_null_r5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> (cur_slice != '0));

    // R7: the restore pointer moves only with a swap.
    p_restore_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_pulse |-> $stable(sp_restore));

    // R9: the running task changes only with a swap.
    p_task_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_pulse |-> $stable(cur_task));

    // R8: the running region is never inverted.
    p_region_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && swap_pulse) |-> (region_lo <= region_hi));

endmodule

bind task_slice_sequencer seq_checker #(
    .NTASK  (NTASK),
    .SLICE_W(SLICE_W),
    .SP_W   (SP_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
) u_seq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_task_count(cfg_task_count),
    .cfg_slice     (cfg_slice),
    .cur_task      (cur_task),
    .swap_pulse    (swap_pulse),
    .sp_restore    (sp_restore),
    .region_lo     (region_lo),
    .region_hi     (region_hi),
    .idle          (idle)
);

// File: tb/sim_task_slice_sequencer.sv
// Directed bench for the time-slice sequencer: one task per scenario.
module sim_task_slice_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_task_count = 3'd4;
    logic [23:0] cfg_slice = '0;
    logic [19:0] cfg_base = '0;
    logic [7:0]  cfg_prescale = '0;
    logic        tick_in = 1'b1;
    logic        yield_req = 1'b0;
    logic [4:0]  sp_cur = '0;
    logic [1:0]  cur_task;
    logic        swap_pulse;
    logic [4:0]  sp_restore;
    logic [4:0]  region_lo;
    logic [4:0]  region_hi;
    logic        idle;

    int  total = 0;
    int  bad = 0;
    bit  half_rate = 1'b0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    task_slice_sequencer u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_task_count(cfg_task_count),
        .cfg_slice     (cfg_slice),
        .cfg_base      (cfg_base),
        .cfg_prescale  (cfg_prescale),
        .tick_in       (tick_in),
        .yield_req     (yield_req),
        .sp_cur        (sp_cur),
        .cur_task      (cur_task),
        .swap_pulse    (swap_pulse),
        .sp_restore    (sp_restore),
        .region_lo     (region_lo),
        .region_hi     (region_hi),
        .idle          (idle)
    );

    // Time-base drive: every cycle, or every other cycle in half-rate mode.
    initial begin
        forever begin
            @(negedge clk);
            tick_in = half_rate ? ~tick_in : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // Load a configuration under reset and release it.
    task automatic setup(input int cnt, input int s0, input int s1, input int s2,
                         input int s3, input int b0, input int b1, input int b2,
                         input int b3, input int pre);
        @(negedge clk);
        rst_n          = 1'b0;
        cfg_task_count = 3'(cnt);
        cfg_slice      = {6'(s3), 6'(s2), 6'(s1), 6'(s0)};
        cfg_base       = {5'(b3), 5'(b2), 5'(b1), 5'(b0)};
        cfg_prescale   = 8'(pre);
        yield_req      = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Count negedges up to and including the next swap pulse.
    task automatic wait_pulse(input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!swap_pulse && n < lim);
    endtask

    // Yield for one cycle; the pulse is visible at the next negedge.
    task automatic yield_once;
        yield_req = 1'b1;
        @(negedge clk);
        yield_req = 1'b0;
    endtask

    task automatic t_reset;
        int n;
        setup(4, 1, 1, 1, 1, 1, 9, 14, 27, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk_eq("R1 pulse in reset", swap_pulse, 0);
        chk_eq("R1 idle in reset", idle, 0);
        chk_eq("R1 task in reset", cur_task, 0);
        rst_n = 1'b1;
        wait_pulse(10, n);
        chk_eq("R1 boot pulse delay", n, 1);
        chk_eq("R1 boot task", cur_task, 0);
        chk_eq("R1 boot restore", sp_restore, 0);
        chk_eq("R8 boot region lo", region_lo, 1);
        chk_eq("R8 boot region hi", region_hi, 8);
    endtask

    task automatic t_expiry;
        int n;
        setup(1, 1, 0, 0, 0, 1, 9, 14, 27, 0);
        wait_pulse(10, n);
        wait_pulse(5000, n);
        chk_eq("R2 period slice1 pre0", n, 256);
        chk_eq("R2 single task kept", cur_task, 0);
        setup(2, 3, 1, 0, 0, 1, 9, 14, 27, 1);
        wait_pulse(10, n);
        wait_pulse(5000, n);
        chk_eq("R2 period slice3 pre1", n, 1536);
        chk_eq("R3 after expiry", cur_task, 1);
        wait_pulse(5000, n);
        chk_eq("R2 period slice1 pre1", n, 512);
        chk_eq("R3 wrap after expiry", cur_task, 0);
        half_rate = 1'b1;
        setup(1, 1, 0, 0, 0, 1, 9, 14, 27, 0);
        wait_pulse(10, n);
        wait_pulse(5000, n);
        wait_pulse(5000, n);
        chk_eq("R2 half-rate tick_in period", n, 512);
        half_rate = 1'b0;
    endtask

    task automatic t_order;
        int n;
        setup(3, 1, 1, 1, 1, 1, 9, 14, 27, 0);
        wait_pulse(10, n);
        yield_once();
        chk_eq("R3 order step1", cur_task, 1);
        yield_once();
        chk_eq("R3 order step2", cur_task, 2);
        yield_once();
        chk_eq("R3 wrap at count", cur_task, 0);
        chk_eq("R3 wrap pulse", swap_pulse, 1);
    endtask

    task automatic t_yield;
        int n;
        setup(4, 1, 1, 1, 1, 1, 9, 14, 27, 0);
        wait_pulse(10, n);
        yield_once();
        chk_eq("R4 yield pulse", swap_pulse, 1);
        chk_eq("R4 yield task", cur_task, 1);
        @(negedge clk);
        chk_eq("R9 pulse width", swap_pulse, 0);
        repeat (254) @(negedge clk);
        chk_eq("R4 no early expiry", swap_pulse, 0);
        yield_once();
        chk_eq("R4 coincident pulse", swap_pulse, 1);
        chk_eq("R4 coincident single step", cur_task, 2);
        @(negedge clk);
        chk_eq("R4 no second pulse", swap_pulse, 0);
        chk_eq("R4 task held", cur_task, 2);
    endtask

    task automatic t_null;
        int n;
        setup(4, 2, 0, 0, 3, 1, 9, 14, 27, 0);
        wait_pulse(10, n);
        chk_eq("R5 boot live", cur_task, 0);
        yield_once();
        chk_eq("R5 skip empties", cur_task, 3);
        yield_once();
        chk_eq("R5 skip to wrap", cur_task, 0);
        setup(4, 0, 0, 5, 0, 1, 9, 14, 27, 0);
        wait_pulse(10, n);
        chk_eq("R5 boot skips empties", cur_task, 2);
        yield_once();
        chk_eq("R5 lone task pulse", swap_pulse, 1);
        chk_eq("R5 lone task reselected", cur_task, 2);
    endtask

    task automatic t_idle;
        int pulses = 0;
        setup(4, 0, 0, 0, 0, 1, 9, 14, 27, 0);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (swap_pulse) pulses++;
        end
        chk_eq("R6 idle all empty", idle, 1);
        chk_eq("R6 no pulses all empty", pulses, 0);
        pulses = 0;
        setup(0, 1, 1, 1, 1, 1, 9, 14, 27, 0);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (swap_pulse) pulses++;
        end
        chk_eq("R6 idle count zero", idle, 1);
        chk_eq("R6 no pulses count zero", pulses, 0);
    endtask

    task automatic t_ctx;
        int n;
        setup(2, 10, 10, 0, 0, 1, 17, 0, 0, 0);
        wait_pulse(10, n);
        chk_eq("R7 first restore", sp_restore, 0);
        chk_eq("R8 lo task0", region_lo, 1);
        chk_eq("R8 hi task0", region_hi, 16);
        sp_cur = 5'd5;
        yield_once();
        chk_eq("R7 fresh task restore", sp_restore, 16);
        chk_eq("R8 lo last task", region_lo, 17);
        chk_eq("R8 hi last task", region_hi, 31);
        sp_cur = 5'd20;
        yield_once();
        chk_eq("R7 saved task0 restore", sp_restore, 5);
        sp_cur = 5'd7;
        yield_once();
        chk_eq("R7 saved task1 restore", sp_restore, 20);
        @(negedge clk);
        chk_eq("R7 restore held", sp_restore, 20);
    endtask

    task automatic t_region;
        int n;
        setup(4, 9, 9, 9, 9, 1, 9, 14, 27, 0);
        wait_pulse(10, n);
        yield_once();
        chk_eq("R8 lo task1", region_lo, 9);
        chk_eq("R8 hi task1", region_hi, 13);
        yield_once();
        chk_eq("R8 lo task2", region_lo, 14);
        chk_eq("R8 hi task2", region_hi, 26);
        yield_once();
        chk_eq("R8 lo task3", region_lo, 27);
        chk_eq("R8 hi task3", region_hi, 31);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_expiry();
        t_order();
        t_yield();
        t_null();
        t_idle();
        t_ctx();
        t_region();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule